// File: doc/BRIEF.md
# Bit-Slip Tolerant Sync Hunter and Frame Extractor

This block sits behind a radio byte receiver whose byte boundaries bear no fixed relation to the packet's bits. Every byte that arrives while the block is hunting is pushed into a four-byte window. That window is compared against eight fixed 32-bit images of the tail of the preamble followed by the sync word. Each image corresponds to one bit lag, from 0 to 7. When one of them matches, the block records the lag as a 3-bit alignment code, latches the current signal-strength input and starts receiving.

While receiving, each new byte is joined with the byte received before it. The 16-bit pair is shifted so that the original byte boundary is restored, and the recovered byte is written into a payload memory. Frame position 0 is the sync tail byte (value 0x00), and position 1 is the length byte. The length counts every stored byte, including those two.

When the stored count reaches the length, the block raises a ready flag and holds the frame until the host acknowledges it. Meanwhile the host can read the payload through a synchronous read port. After the acknowledgement the block returns to hunting with an empty window.

Top module: `bitslip_deframer`

## Requirements
- R1: While reset is high, and on the first edge after it, pkt_ready and rx_busy are 0, pkt_len is 0, link_rssi is 0 and align_code is 0.
- R2: While hunting, if the four most recent valid bytes (oldest first) are AA D3 91 00, the block enters receive with align_code 0. That fourth byte is stored as frame position 0.
- R3: While hunting, a window of 55 69 C8 80, AA B4 E4 40, 55 5A 72 20 or AA AD 39 10 enters receive with align_code 1, 2, 3 or 4 respectively. These codes are restored by a left shift of that many bits.
- R4: While hunting, a window of 55 56 9C 88, AA AB 4E 44 or 55 55 A7 22 enters receive with align_code 5, 6 or 7 respectively. These codes are restored by a right shift of 3, 2 or 1 bits.
- R5: link_rssi takes the value of rssi_in on the byte that completes a match. It then holds until the next match.
- R6: In receive, each valid byte stores the upper byte of ({previous byte, new byte} << align_code); with code 0 the new byte is stored as is. Cycles with in_valid low change nothing.
- R7: The byte at frame position 1 is the length L. When the stored count reaches L, pkt_ready rises on the edge that stores the last byte, and pkt_len shows L at the same time.
- R8: While pkt_ready is high, incoming bytes are dropped: the frame memory, pkt_len and rx_busy do not change. An ack then clears pkt_ready on the next edge and resumes hunting. An ack at any other time has no effect.
- R9: A length byte below 3 or above DEPTH aborts the frame. The block goes back to hunting without raising pkt_ready. A length of exactly DEPTH is accepted.
- R10: rd_data shows the byte stored at rd_addr one edge after rd_addr is presented.
- R11: Windows that match no pattern keep the block hunting with rx_busy low. After an abort or an ack, the window starts out empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | in_byte carries a received byte this cycle |
| in_byte | input | 8 | Received byte, unaligned |
| rssi_in | input | RSSI_W | Current signal-strength reading |
| ack | input | 1 | Host has consumed the held frame |
| rd_addr | input | $clog2(DEPTH) | Frame memory read address |
| rd_data | output | 8 | Frame memory read data, one cycle latency |
| pkt_ready | output | 1 | A complete frame is held |
| pkt_len | output | 8 | Length of the held frame in bytes |
| rx_busy | output | 1 | A frame is being received |
| link_rssi | output | RSSI_W | Signal strength latched at the sync match |
| align_code | output | 3 | Bit lag of the last sync match |

## Verification
The alignment code, the latched strength and rx_busy change on the same edge that takes in the byte completing a match. pkt_ready and pkt_len change on the edge that stores the last frame byte, and rd_data follows rd_addr by one edge. The bench drives inputs at the falling edge and updates its behavioural model at the rising edge. It compares every output at the next falling edge, so each result is sampled half a cycle after the edge that produced it. Frame contents are checked against the bytes the bench encoded before it shifted them. The bench reads them one address per cycle and samples rd_data a full cycle after each address is presented.

// File: rtl/bitslip_pkg.sv
package bitslip_pkg;

  typedef enum logic [1:0] {
    DF_HUNT = 2'd0,
    DF_RECV = 2'd1,
    DF_HOLD = 2'd2
  } dfr_state_e;

  typedef enum logic [1:0] {
    SL_NONE  = 2'd0,
    SL_LEFT  = 2'd1,
    SL_RIGHT = 2'd2
  } slip_dir_e;

  typedef struct packed {
    slip_dir_e   dir;
    logic [2:0]  amt;
  } slip_t;

  localparam int unsigned SLIP_LANES = 8;
  localparam int unsigned SLIP_CODE_W = $clog2(SLIP_LANES);

  // Preamble tail plus sync image; lane N is this sequence delayed by N bits.
  localparam logic [39:0] SYNC_SEED = 40'hAA_AAD3_9100;

  function automatic logic [31:0] lane_pattern(input int unsigned lag);
    logic [39:0] t;
    t = SYNC_SEED >> lag;
    return t[31:0];
  endfunction

  // Codes 1..4 restore with a left shift, 5..7 with a right shift of 8-code.
  function automatic slip_t slip_of(input logic [2:0] code);
    slip_t s;
    if (code == 3'd0) begin
      s.dir = SL_NONE;
      s.amt = 3'd0;
    end else if (code <= 3'd4) begin
      s.dir = SL_LEFT;
      s.amt = code;
    end else begin
      s.dir = SL_RIGHT;
      s.amt = 3'd0 - code;
    end
    return s;
  endfunction

endpackage

// File: rtl/bitslip_window.sv
module bitslip_window
  import bitslip_pkg::*;
#(
  parameter int LANES = SLIP_LANES
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   shift_en,
  input  logic                   clear,
  input  logic [7:0]             in_byte,
  output logic                   hit,
  output logic [$clog2(LANES)-1:0] hit_code
);

  localparam int CODE_W = $clog2(LANES);

  logic [31:0]      win_q;
  logic [31:0]      win_nxt;
  logic [LANES-1:0] lane_hit;

  assign win_nxt = {win_q[23:0], in_byte};

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      localparam logic [31:0] PAT = lane_pattern(g);
      logic older_ok;
      logic newer_ok;
      assign older_ok    = (win_nxt[31:16] == PAT[31:16]);
      assign newer_ok    = (win_nxt[15:0]  == PAT[15:0]);
      assign lane_hit[g] = older_ok && newer_ok;
    end
  endgenerate

  always_comb begin
    hit_code = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (lane_hit[i]) hit_code = CODE_W'(i);
    end
  end

  assign hit = shift_en && (|lane_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q <= '0;
    end else if (clear) begin
      win_q <= '0;
    end else if (shift_en) begin
      win_q <= win_nxt;
    end
  end

endmodule

// File: rtl/bitslip_realign.sv
module bitslip_realign
  import bitslip_pkg::*;
(
  input  logic [7:0] prev_byte,
  input  logic [7:0] cur_byte,
  input  logic [2:0] code,
  output logic [7:0] out_byte
);

  slip_t       sl;
  logic [15:0] pair;
  logic [15:0] lsh;
  logic [15:0] rsh;

  assign sl   = slip_of(code);
  assign pair = {prev_byte, cur_byte};
  assign lsh  = pair << sl.amt;
  assign rsh  = pair >> sl.amt;

  always_comb begin
    unique case (sl.dir)
      SL_LEFT:  out_byte = lsh[15:8];
      SL_RIGHT: out_byte = rsh[7:0];
      default:  out_byte = cur_byte;
    endcase
  end

endmodule

// File: rtl/bitslip_store.sv
module bitslip_store #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/bitslip_deframer.sv
module bitslip_deframer
  import bitslip_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int RSSI_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [7:0]               in_byte,
  input  logic [RSSI_W-1:0]        rssi_in,
  input  logic                     ack,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic [7:0]               rd_data,
  output logic                     pkt_ready,
  output logic [7:0]               pkt_len,
  output logic                     rx_busy,
  output logic [RSSI_W-1:0]        link_rssi,
  output logic [2:0]               align_code
);

  localparam int AW      = $clog2(DEPTH);
  localparam int CW      = $clog2(DEPTH + 1);
  localparam int LEN_IDX = 1;
  localparam int MIN_LEN = 3;

  dfr_state_e        state_q, state_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [7:0]        len_q, len_d;
  logic [7:0]        prev_q, prev_d;
  logic [2:0]        code_q, code_d;
  logic [RSSI_W-1:0] rssi_q, rssi_d;
  logic              ready_q, ready_d;
  logic [7:0]        plen_q, plen_d;
  logic              busy_q;

  logic              hunt_shift;
  logic              win_hit;
  logic [2:0]        win_code;
  logic              go_hunt;
  logic [7:0]        slip_byte;
  logic              wr_en;
  logic [AW-1:0]     wr_addr;
  logic [7:0]        wr_data;
  logic [8:0]        cnt_ext;
  logic              len_ok;
  logic              at_len_idx;
  logic              frame_done;

  assign hunt_shift = in_valid && (state_q == DF_HUNT);

  bitslip_window #(.LANES(SLIP_LANES)) u_window (
    .clk      (clk),
    .rst      (rst),
    .shift_en (hunt_shift),
    .clear    (go_hunt),
    .in_byte  (in_byte),
    .hit      (win_hit),
    .hit_code (win_code)
  );

  bitslip_realign u_realign (
    .prev_byte (prev_q),
    .cur_byte  (in_byte),
    .code      (code_q),
    .out_byte  (slip_byte)
  );

  bitslip_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  assign cnt_ext    = 9'(cnt_q) + 9'd1;
  assign at_len_idx = (cnt_q == CW'(LEN_IDX));
  assign len_ok     = (slip_byte >= 8'(MIN_LEN)) && ({1'b0, slip_byte} <= 9'(DEPTH));
  assign frame_done = (cnt_q > CW'(LEN_IDX)) && (cnt_ext == {1'b0, len_q});

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    len_d   = len_q;
    prev_d  = prev_q;
    code_d  = code_q;
    rssi_d  = rssi_q;
    ready_d = ready_q;
    plen_d  = plen_q;
    wr_en   = 1'b0;
    wr_addr = cnt_q[AW-1:0];
    wr_data = slip_byte;
    go_hunt = 1'b0;
    unique case (state_q)
      DF_HUNT: begin
        if (win_hit) begin
          state_d = DF_RECV;
          code_d  = win_code;
          rssi_d  = rssi_in;
          prev_d  = in_byte;
          if (win_code == 3'd0) begin
            wr_en   = 1'b1;
            wr_addr = '0;
            wr_data = in_byte;
            cnt_d   = CW'(1);
          end else begin
            cnt_d   = '0;
          end
        end
      end
      DF_RECV: begin
        if (in_valid) begin
          wr_en  = 1'b1;
          prev_d = in_byte;
          cnt_d  = cnt_q + CW'(1);
          if (at_len_idx) begin
            if (len_ok) begin
              len_d = slip_byte;
            end else begin
              state_d = DF_HUNT;
              cnt_d   = '0;
              go_hunt = 1'b1;
            end
          end else if (frame_done) begin
            state_d = DF_HOLD;
            ready_d = 1'b1;
            plen_d  = len_q;
          end
        end
      end
      DF_HOLD: begin
        if (ack) begin
          state_d = DF_HUNT;
          ready_d = 1'b0;
          cnt_d   = '0;
          go_hunt = 1'b1;
        end
      end
      default: begin
        state_d = DF_HUNT;
        go_hunt = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= DF_HUNT;
      cnt_q   <= '0;
      len_q   <= '0;
      prev_q  <= '0;
      code_q  <= '0;
      rssi_q  <= '0;
      ready_q <= 1'b0;
      plen_q  <= '0;
      busy_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      len_q   <= len_d;
      prev_q  <= prev_d;
      code_q  <= code_d;
      rssi_q  <= rssi_d;
      ready_q <= ready_d;
      plen_q  <= plen_d;
      busy_q  <= (state_d == DF_RECV);
    end
  end

  assign pkt_ready  = ready_q;
  assign pkt_len    = plen_q;
  assign rx_busy    = busy_q;
  assign link_rssi  = rssi_q;
  assign align_code = code_q;

endmodule

// File: rtl/bitslip_deframer_chk.sv
module bitslip_deframer_chk #(
  parameter int DEPTH  = 64,
  parameter int RSSI_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ack,
  input logic              pkt_ready,
  input logic [7:0]        pkt_len,
  input logic              rx_busy,
  input logic [RSSI_W-1:0] link_rssi,
  input logic [2:0]        align_code
);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!pkt_ready && !rx_busy));

  a_r8_ready_held: assert property (@(posedge clk) disable iff (rst)
    (pkt_ready && !ack) |=> pkt_ready);

  a_r8_ack_release: assert property (@(posedge clk) disable iff (rst)
    (pkt_ready && ack) |=> (!pkt_ready && !rx_busy));

  a_r8_len_stable: assert property (@(posedge clk) disable iff (rst)
    (pkt_ready && $past(pkt_ready)) |-> $stable(pkt_len));

  a_r7_rise_after_busy: assert property (@(posedge clk) disable iff (rst)
    $rose(pkt_ready) |-> $past(rx_busy));

  a_r7_not_both: assert property (@(posedge clk) disable iff (rst)
    !(pkt_ready && rx_busy));

  a_r9_len_range: assert property (@(posedge clk) disable iff (rst)
    pkt_ready |-> ((pkt_len >= 8'd3) && ({1'b0, pkt_len} <= 9'(DEPTH))));

  a_r5_rssi_hold: assert property (@(posedge clk) disable iff (rst)
    (rx_busy && $past(rx_busy)) |-> $stable(link_rssi));

  a_r2_code_hold: assert property (@(posedge clk) disable iff (rst)
    ((rx_busy || pkt_ready) && $past(rx_busy || pkt_ready)) |-> $stable(align_code));

endmodule

bind bitslip_deframer bitslip_deframer_chk #(.DEPTH(DEPTH), .RSSI_W(RSSI_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ack        (ack),
  .pkt_ready  (pkt_ready),
  .pkt_len    (pkt_len),
  .rx_busy    (rx_busy),
  .link_rssi  (link_rssi),
  .align_code (align_code)
);

// File: tb/bitslip_deframer_bench.sv
`timescale 1ns/1ps
module bitslip_deframer_bench;

  localparam int DEPTH  = 64;
  localparam int RSSI_W = 8;
  localparam int AW     = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [7:0]    in_byte = 8'h00;
  logic [7:0]    rssi_in = 8'h00;
  logic          ack = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    rd_data;
  logic          pkt_ready;
  logic [7:0]    pkt_len;
  logic          rx_busy;
  logic [7:0]    link_rssi;
  logic [2:0]    align_code;

  bitslip_deframer #(.DEPTH(DEPTH), .RSSI_W(RSSI_W)) u_bitslip_deframer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .rssi_in(rssi_in), .ack(ack), .rd_addr(rd_addr), .rd_data(rd_data),
    .pkt_ready(pkt_ready), .pkt_len(pkt_len), .rx_busy(rx_busy),
    .link_rssi(link_rssi), .align_code(align_code)
  );

  always #2.5 clk = ~clk;

  int total = 0;
  int bad   = 0;

  // Behavioural reference
  logic [31:0] pats [8] = '{32'hAAD39100, 32'h5569C880, 32'hAAB4E440, 32'h555A7220,
                            32'hAAAD3910, 32'h55569C88, 32'hAAAB4E44, 32'h5555A722};
  int          m_st, m_cnt, m_len, m_plen, m_code, m_rssi;
  bit          m_ready;
  logic [31:0] m_w;
  logic [7:0]  m_prev;
  logic [7:0]  m_mem [DEPTH];

  always @(posedge clk) begin : ref_model
    int          hitc;
    logic [15:0] pr;
    logic [7:0]  ob;
    if (rst) begin
      m_st = 0; m_cnt = 0; m_len = 0; m_plen = 0; m_code = 0; m_rssi = 0;
      m_ready = 0; m_w = 0; m_prev = 0;
    end else begin
      case (m_st)
        0: if (in_valid) begin
          m_w = {m_w[23:0], in_byte};
          hitc = -1;
          for (int k = 0; k < 8; k++) if (hitc < 0 && m_w == pats[k]) hitc = k;
          if (hitc >= 0) begin
            m_st = 1; m_code = hitc; m_rssi = rssi_in; m_prev = in_byte;
            if (hitc == 0) begin m_mem[0] = in_byte; m_cnt = 1; end
            else m_cnt = 0;
          end
        end
        1: if (in_valid) begin
          pr = {m_prev, in_byte} << m_code;
          ob = (m_code == 0) ? in_byte : pr[15:8];
          m_mem[m_cnt] = ob;
          m_prev = in_byte;
          m_cnt++;
          if (m_cnt == 2) begin
            if (ob < 3 || ob > DEPTH) begin m_st = 0; m_cnt = 0; m_w = 0; end
            else m_len = ob;
          end else if (m_cnt > 2 && m_cnt == m_len) begin
            m_st = 2; m_ready = 1; m_plen = m_len;
          end
        end
        default: if (ack) begin
          m_st = 0; m_ready = 0; m_cnt = 0; m_w = 0;
        end
      endcase
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    chk(pkt_ready === m_ready, "R7 ready vs model", int'(pkt_ready), int'(m_ready));
    chk(rx_busy === (m_st == 1), "R11 busy vs model", int'(rx_busy), int'(m_st == 1));
    chk(pkt_len === 8'(m_plen), "R7 length vs model", int'(pkt_len), m_plen);
    chk(link_rssi === 8'(m_rssi), "R5 rssi vs model", int'(link_rssi), m_rssi);
    chk(align_code === 3'(m_code), "R2 R3 R4 code vs model", int'(align_code), m_code);
  endtask

  task automatic send(input logic [7:0] b);
    in_valid = 1'b1; in_byte = b; cyc();
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) cyc();
  endtask

  function automatic logic [7:0] pay(input int base, input int k);
    return 8'(base * 13 + k * 29 + 7);
  endfunction

  // Encode an aligned frame and deliver it lagged by c bits.
  task automatic send_frame(input int c, input int len, input int base, input int gap);
    logic [7:0]  s [80];
    logic [15:0] pr;
    int n, npay;
    npay = (len >= 3 && len <= DEPTH) ? len - 2 : 4;
    s[0] = 8'hAA; s[1] = 8'hAA; s[2] = 8'hAA; s[3] = 8'hD3; s[4] = 8'h91; s[5] = 8'h00;
    s[6] = 8'(len);
    for (int k = 0; k < npay; k++) s[7 + k] = pay(base, k);
    n = 7 + npay;
    s[n] = 8'h00; s[n + 1] = 8'h00;
    n = n + 2;
    for (int j = 1; j < n; j++) begin
      pr = {s[j - 1], s[j]} >> c;
      rssi_in = 8'(base + j);
      send(pr[7:0]);
      if (gap > 0) idle(gap);
    end
    in_valid = 1'b0;
  endtask

  task automatic read_at(input int a, output logic [7:0] v);
    rd_addr = AW'(a);
    cyc();
    v = rd_data;
  endtask

  task automatic check_frame(input int c, input int len, input int base);
    logic [7:0] v, e;
    string tg;
    tg = (c == 0) ? "R2 code" : ((c <= 4) ? "R3 code" : "R4 code");
    chk(pkt_ready === 1'b1, "R7 ready after frame", int'(pkt_ready), 1);
    chk(pkt_len === 8'(len), "R7 pkt_len", int'(pkt_len), len);
    chk(align_code === 3'(c), tg, int'(align_code), c);
    chk(link_rssi === 8'(base + 5), "R5 rssi at match", int'(link_rssi), (base + 5) & 255);
    for (int k = 0; k < len; k++) begin
      e = (k == 0) ? 8'h00 : ((k == 1) ? 8'(len) : pay(base, k - 2));
      read_at(k, v);
      chk(v === e, "R6 R10 frame byte", int'(v), int'(e));
    end
  endtask

  task automatic release_frame();
    ack = 1'b1; cyc();
    ack = 1'b0; cyc();
    chk(pkt_ready === 1'b0, "R8 ack clears ready", int'(pkt_ready), 0);
  endtask

  initial begin : watchdog
    #900000;
    total++; bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    repeat (4) cyc();
    // R1 reset values
    chk(pkt_ready === 1'b0, "R1 ready", int'(pkt_ready), 0);
    chk(rx_busy === 1'b0, "R1 busy", int'(rx_busy), 0);
    chk(pkt_len === 8'h00, "R1 pkt_len", int'(pkt_len), 0);
    chk(link_rssi === 8'h00, "R1 rssi", int'(link_rssi), 0);
    chk(align_code === 3'd0, "R1 code", int'(align_code), 0);
    rst = 1'b0;
    idle(2);

    // R11 noise keeps hunting
    for (int i = 0; i < 20; i++) send(8'(i * 37 + 5));
    chk(rx_busy === 1'b0, "R11 noise no sync", int'(rx_busy), 0);

    // R8 ack outside hold ignored
    ack = 1'b1; cyc(); ack = 1'b0; cyc();
    chk(pkt_ready === 1'b0 && rx_busy === 1'b0, "R8 stray ack", int'(pkt_ready), 0);

    // Every bit lag
    for (int c = 0; c < 8; c++) begin
      send_frame(c, 4 + c * 3, 16 * c + 3, 0);
      check_frame(c, 4 + c * 3, 16 * c + 3);
      if (c == 0) begin
        // R8: a whole new frame during hold is dropped
        send_frame(0, 5, 99, 0);
        chk(rx_busy === 1'b0, "R8 busy stays low in hold", int'(rx_busy), 0);
        chk(pkt_len === 8'd4, "R8 pkt_len unchanged", int'(pkt_len), 4);
        read_at(1, v);
        chk(v === 8'd4, "R8 memory unchanged", int'(v), 4);
        read_at(2, v);
        chk(v === pay(3, 0), "R8 payload unchanged", int'(v), int'(pay(3, 0)));
      end
      release_frame();
      idle(2);
    end

    // R6 gaps between bytes
    send_frame(6, 9, 77, 2);
    check_frame(6, 9, 77);
    release_frame();

    // R9 aborts
    send_frame(2, 2, 40, 0);
    idle(2);
    chk(pkt_ready === 1'b0 && rx_busy === 1'b0, "R9 length 2 aborts", int'(pkt_ready), 0);
    send_frame(5, DEPTH + 1, 50, 0);
    idle(2);
    chk(pkt_ready === 1'b0 && rx_busy === 1'b0, "R9 length over depth aborts", int'(pkt_ready), 0);

    // R9 R7 boundary lengths
    send_frame(3, DEPTH, 60, 0);
    check_frame(3, DEPTH, 60);
    release_frame();
    send_frame(7, 3, 70, 1);
    check_frame(7, 3, 70);
    release_frame();
    idle(4);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule